// File: doc/BRIEF.md
# Scalar ALU with condition flag

This unit executes one two-source, one-destination scalar instruction per clock. It is handed the upper half of a 32-bit instruction word, which holds the format tag, opcode and destination index, along with two operand values that upstream logic has already fetched. It performs 32-bit add and subtract operations in unsigned, signed, carry and borrow forms. It also performs signed and unsigned min and max, conditional select, eight bitwise logical operations, three shifts, a signed multiply and an absolute difference.

A single condition bit is kept across instructions. Each class of operation updates it by its own rule: carry or borrow, signed overflow, "first operand was chosen", result non-zero, or no change at all. Add-with-carry, subtract-with-borrow and select read the bit back. Results appear one clock after the valid strobe, together with the destination index and an illegal-instruction flag. A side port writes the condition bit directly.

The parameter `NUMBERING` picks between two opcode maps. In map 1 the two slots just below the logical group are removed, so every opcode from the logical group upward is 2 lower than in map 0.

Top module: `salu_core`

## Requirements
- R1: After reset `out_valid`, `out_illegal`, `out_result`, `out_dst` and `scc` are all 0.
- R2: `out_valid` is high exactly one clock after `in_valid`. A legal word loads `out_result` and `out_dst` (word bits 22:16, i.e. `ins_hi[6:0]`) in that clock. With no valid word and no flag write, result and flag hold.
- R3: Unsigned add (opcode 0) and add-with-carry (opcode 4, incoming flag added as carry-in) write the 32-bit sum and set the flag to the carry out of bit 31.
- R4: Unsigned subtract (opcode 1) and subtract-with-borrow (opcode 5, incoming flag also subtracted) write the wrapped difference and set the flag to the borrow.
- R5: Signed add (opcode 2) and signed subtract (opcode 3) write the wrapped result and set the flag only when the exact result lies outside the signed 32-bit range.
- R6: Signed min (6), unsigned min (7), signed max (8) and unsigned max (9) write the chosen operand and set the flag to 1 exactly when the first source was chosen. Equal operands choose the second source and clear the flag.
- R7: Select (opcode 10) writes the first source when the flag is 1 and the second otherwise, and leaves the flag unchanged.
- R8: The logical operations AND, OR, XOR, AND-with-inverted-b, OR-with-inverted-b, NAND, NOR and XNOR set the flag when the result is non-zero. In map 0 their opcodes are 14, 16, 18, 20, 22, 24, 26, 28.
- R9: Left shift (map 0: 30), logical right shift (32) and arithmetic right shift (34) use only the low 5 bits of the second source as the shift amount, and set the flag when the result is non-zero.
- R10: Multiply (map 0: 38) writes the low 32 bits of the product and keeps the flag. Absolute difference (map 0: 44) writes |a−b| of the signed operands and sets the flag when that result is non-zero.
- R11: In map 1, opcodes 0–11 are unchanged and every opcode at 14 or above in map 0 is 2 lower. Opcodes 12 and 13 are unassigned in map 0 and are AND and the unassigned slot 13 in map 1.
- R12: A valid word whose tag (bits 31:30) is not 2'b10, or whose opcode is unassigned in the selected map (including 11 and the 64-bit slots), sets `out_illegal` for one clock and leaves the result, destination and flag unchanged.
- R13: `flag_wr_en` loads `flag_wr_val` into the flag on the next clock, and it takes priority over any flag update from an instruction in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| ins_hi | input | 16 | Instruction word bits 31:16 (tag, opcode, destination) |
| src_a | input | 32 | First source value |
| src_b | input | 32 | Second source value |
| flag_wr_en | input | 1 | Direct flag write enable |
| flag_wr_val | input | 1 | Value for direct flag write |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_illegal | output | 1 | Rejected instruction indicator |
| out_dst | output | 7 | Destination index of last legal instruction |
| out_result | output | 32 | Result of last legal instruction |
| scc | output | 1 | Current condition flag |

## Verification
The hardest states to reach are the ones where the condition bit carries information from one instruction into the next: a carry chained through add-with-carry, a borrow fed into subtract-with-borrow, a select that follows a flag produced by min or max, and a flag write that collides with a flag-producing instruction. The stimulus sets these up by preloading the flag through the side port and then issuing the consuming instruction. A long run of random back-to-back words then mixes every class, so that whichever flag one word leaves behind is consumed by the next. Two copies of the unit, one per opcode map, receive the same operations encoded for their own map. Opcode 12 is also sent raw to both, which makes it illegal in one copy and AND in the other.

// File: rtl/salu_pkg.sv
package salu_pkg;

  typedef enum logic [4:0] {
    OP_ADDU, OP_SUBU, OP_ADDI, OP_SUBI, OP_ADDC, OP_SUBB,
    OP_MINI, OP_MINU, OP_MAXI, OP_MAXU, OP_CSEL,
    OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_NAND, OP_NOR, OP_XNOR,
    OP_SHL, OP_SHR, OP_ASR, OP_MUL, OP_ABSD, OP_BAD
  } salu_op_e;

  localparam logic [1:0] FMT_TAG = 2'b10;
  localparam int OPC_W = 7;
  localparam int DST_W = 7;

endpackage

// File: rtl/salu_decode.sv
module salu_decode
  import salu_pkg::*;
#(
  parameter int NUMBERING = 0
) (
  input  logic [15:0]      word_hi,
  output salu_op_e         op,
  output logic             legal,
  output logic [DST_W-1:0] dst
);

  logic [1:0]       tag;
  logic [OPC_W-1:0] opc;
  logic [OPC_W:0]   norm;

  assign tag = word_hi[15:14];
  assign opc = word_hi[13:7];
  assign dst = word_hi[DST_W-1:0];

  // Fold the selected map onto map 0 so one case table serves both.
  generate
    if (NUMBERING != 0) begin : g_map1
      assign norm = (opc >= OPC_W'(12)) ? ({1'b0, opc} + (OPC_W+1)'(2)) : {1'b0, opc};
    end else begin : g_map0
      assign norm = {1'b0, opc};
    end
  endgenerate

  always_comb begin
    case (norm)
      8'd0:    op = OP_ADDU;
      8'd1:    op = OP_SUBU;
      8'd2:    op = OP_ADDI;
      8'd3:    op = OP_SUBI;
      8'd4:    op = OP_ADDC;
      8'd5:    op = OP_SUBB;
      8'd6:    op = OP_MINI;
      8'd7:    op = OP_MINU;
      8'd8:    op = OP_MAXI;
      8'd9:    op = OP_MAXU;
      8'd10:   op = OP_CSEL;
      8'd14:   op = OP_AND;
      8'd16:   op = OP_OR;
      8'd18:   op = OP_XOR;
      8'd20:   op = OP_ANDN;
      8'd22:   op = OP_ORN;
      8'd24:   op = OP_NAND;
      8'd26:   op = OP_NOR;
      8'd28:   op = OP_XNOR;
      8'd30:   op = OP_SHL;
      8'd32:   op = OP_SHR;
      8'd34:   op = OP_ASR;
      8'd38:   op = OP_MUL;
      8'd44:   op = OP_ABSD;
      default: op = OP_BAD;
    endcase
  end

  assign legal = (tag == FMT_TAG) && (op != OP_BAD);

endmodule

// File: rtl/salu_exec.sv
module salu_exec
  import salu_pkg::*;
#(
  parameter int W = 32
) (
  input  salu_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         scc_in,
  output logic [W-1:0] res,
  output logic         scc_we,
  output logic         scc_nx
);

  localparam int SH_W = $clog2(W);

  logic           cin, bin;
  logic [W:0]     sum, dif;
  logic           ovf_add, ovf_sub;
  logic           lt_s, lt_u, gt_s, gt_u;
  logic [SH_W-1:0] sh;
  logic [W-1:0]   prod;

  assign cin = (op == OP_ADDC) & scc_in;
  assign bin = (op == OP_SUBB) & scc_in;
  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign dif = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};

  assign ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);

  assign lt_s = $signed(a) < $signed(b);
  assign gt_s = $signed(a) > $signed(b);
  assign lt_u = a < b;
  assign gt_u = a > b;

  assign sh   = b[SH_W-1:0];
  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADDU, OP_ADDC, OP_ADDI: res = sum[W-1:0];
      OP_SUBU, OP_SUBB, OP_SUBI: res = dif[W-1:0];
      OP_MINI: res = lt_s ? a : b;
      OP_MINU: res = lt_u ? a : b;
      OP_MAXI: res = gt_s ? a : b;
      OP_MAXU: res = gt_u ? a : b;
      OP_CSEL: res = scc_in ? a : b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ANDN: res = a & ~b;
      OP_ORN:  res = a | ~b;
      OP_NAND: res = ~(a & b);
      OP_NOR:  res = ~(a | b);
      OP_XNOR: res = ~(a ^ b);
      OP_SHL:  res = a << sh;
      OP_SHR:  res = a >> sh;
      OP_ASR:  res = W'($signed(a) >>> sh);
      OP_MUL:  res = prod;
      OP_ABSD: res = lt_s ? (b - a) : (a - b);
      default: res = '0;
    endcase
  end

  always_comb begin
    scc_we = 1'b1;
    case (op)
      OP_ADDU, OP_ADDC: scc_nx = sum[W];
      OP_SUBU, OP_SUBB: scc_nx = dif[W];
      OP_ADDI:          scc_nx = ovf_add;
      OP_SUBI:          scc_nx = ovf_sub;
      OP_MINI:          scc_nx = lt_s;
      OP_MINU:          scc_nx = lt_u;
      OP_MAXI:          scc_nx = gt_s;
      OP_MAXU:          scc_nx = gt_u;
      OP_CSEL, OP_MUL, OP_BAD: begin
        scc_we = 1'b0;
        scc_nx = scc_in;
      end
      default:          scc_nx = |res;
    endcase
  end

endmodule

// File: rtl/salu_core.sv
module salu_core
  import salu_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUMBERING = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      ins_hi,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic             flag_wr_en,
  input  logic             flag_wr_val,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [DST_W-1:0] out_dst,
  output logic [W-1:0]     out_result,
  output logic             scc
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  salu_op_e         op;
  logic             legal;
  logic [DST_W-1:0] dst;
  logic [W-1:0]     res_nx;
  logic             scc_we, scc_nx;

  salu_decode #(.NUMBERING(NUMBERING)) u_dec (
    .word_hi (ins_hi),
    .op      (op),
    .legal   (legal),
    .dst     (dst)
  );

  salu_exec #(.W(W)) u_exe (
    .op     (op),
    .a      (src_a),
    .b      (src_b),
    .scc_in (scc),
    .res    (res_nx),
    .scc_we (scc_we),
    .scc_nx (scc_nx)
  );

  logic res_en, scc_en, vld_d, ill_d, scc_d;

  always_comb begin
    vld_d  = in_valid;
    ill_d  = in_valid & ~legal;
    res_en = in_valid & legal;
    scc_en = flag_wr_en | (res_en & scc_we);
    scc_d  = flag_wr_en ? flag_wr_val : scc_nx;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= vld_d;
      out_illegal <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_result <= '0;
      out_dst    <= '0;
    end else if (res_en) begin
      out_result <= res_nx;
      out_dst    <= dst;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      scc <= 1'b0;
    end else if (scc_en) begin
      scc <= scc_d;
    end
  end

endmodule

// File: rtl/salu_core_chk.sv
module salu_core_chk #(
  parameter int W         = 32,
  parameter int NUMBERING = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [15:0]  ins_hi,
  input logic         flag_wr_en,
  input logic         flag_wr_val,
  input logic         out_valid,
  input logic         out_illegal,
  input logic [W-1:0] out_result,
  input logic         scc
);

  localparam logic [6:0] OPC_SEL = 7'd10;
  localparam logic [6:0] OPC_MUL = (NUMBERING != 0) ? 7'd36 : 7'd38;

  logic tag_ok;
  assign tag_ok = ins_hi[15:14] == 2'b10;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flag_wr_en) |=> ($stable(out_result) && $stable(scc)));

  p_ill_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);

  p_ill_keeps_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> $stable(out_result));

  p_sel_keeps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tag_ok && ins_hi[13:7] == OPC_SEL && !flag_wr_en) |=> $stable(scc));

  p_mul_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tag_ok && ins_hi[13:7] == OPC_MUL && !flag_wr_en) |=> $stable(scc));

  p_flag_port_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_en |=> (scc == $past(flag_wr_val)));

endmodule

bind salu_core salu_core_chk #(.W(W), .NUMBERING(NUMBERING)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .in_valid    (in_valid),
  .ins_hi      (ins_hi),
  .flag_wr_en  (flag_wr_en),
  .flag_wr_val (flag_wr_val),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_result  (out_result),
  .scc         (scc)
);

// File: tb/salu_core_tb.sv
module salu_core_tb;

  localparam int K_ADDU = 0,  K_SUBU = 1,  K_ADDI = 2,  K_SUBI = 3,  K_ADDC = 4;
  localparam int K_SUBB = 5,  K_MINI = 6,  K_MINU = 7,  K_MAXI = 8,  K_MAXU = 9;
  localparam int K_CSEL = 10, K_AND = 11,  K_OR = 12,   K_XOR = 13,  K_ANDN = 14;
  localparam int K_ORN = 15,  K_NAND = 16, K_NOR = 17,  K_XNOR = 18, K_SHL = 19;
  localparam int K_SHR = 20,  K_ASR = 21,  K_MUL = 22,  K_ABSD = 23, K_COUNT = 24;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -SMAX - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, fwe, fwv;
  logic [15:0] ins [2];
  logic [31:0] a, b;
  logic        o_v [2], o_ill [2], o_scc [2];
  logic [6:0]  o_dst [2];
  logic [31:0] o_res [2];

  salu_core #(.NUMBERING(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ins_hi(ins[0]),
    .src_a(a), .src_b(b), .flag_wr_en(fwe), .flag_wr_val(fwv),
    .out_valid(o_v[0]), .out_illegal(o_ill[0]), .out_dst(o_dst[0]),
    .out_result(o_res[0]), .scc(o_scc[0]));

  salu_core #(.NUMBERING(1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ins_hi(ins[1]),
    .src_a(a), .src_b(b), .flag_wr_en(fwe), .flag_wr_val(fwv),
    .out_valid(o_v[1]), .out_illegal(o_ill[1]), .out_dst(o_dst[1]),
    .out_result(o_res[1]), .scc(o_scc[1]));

  int nvec = 0, nbad = 0;
  bit done = 0;
  bit e_v;
  bit e_ill [2];
  bit m_scc [2];
  bit [31:0] m_res [2];
  bit [6:0]  m_dst [2];
  string e_tag;
  int seq = 0;

  function automatic int opc_of(int k, int alt);
    int v;
    case (k)
      K_AND: v = 14;  K_OR: v = 16;   K_XOR: v = 18;  K_ANDN: v = 20;
      K_ORN: v = 22;  K_NAND: v = 24; K_NOR: v = 26;  K_XNOR: v = 28;
      K_SHL: v = 30;  K_SHR: v = 32;  K_ASR: v = 34;  K_MUL: v = 38;
      K_ABSD: v = 44;
      default: v = k;
    endcase
    if (alt != 0 && v >= 14) v = v - 2;
    return v;
  endfunction

  function automatic int kind_of(int opc, int alt);
    for (int k = 0; k < K_COUNT; k++)
      if (opc_of(k, alt) == opc) return k;
    return -1;
  endfunction

  task automatic calc(input int k, input bit [31:0] x, input bit [31:0] y,
                      inout bit s, output bit [31:0] r);
    longint t;
    r = 0;
    case (k)
      K_ADDU: begin t = longint'(x) + longint'(y); r = t[31:0]; s = t[32]; end
      K_ADDC: begin t = longint'(x) + longint'(y) + longint'(s); r = t[31:0]; s = t[32]; end
      K_SUBU: begin t = longint'(x) - longint'(y); r = t[31:0]; s = (t < 0); end
      K_SUBB: begin t = longint'(x) - longint'(y) - longint'(s); r = t[31:0]; s = (t < 0); end
      K_ADDI: begin t = longint'($signed(x)) + longint'($signed(y)); r = t[31:0];
                    s = (t > SMAX) || (t < SMIN); end
      K_SUBI: begin t = longint'($signed(x)) - longint'($signed(y)); r = t[31:0];
                    s = (t > SMAX) || (t < SMIN); end
      K_MINI: begin s = ($signed(x) < $signed(y)); r = s ? x : y; end
      K_MINU: begin s = (x < y); r = s ? x : y; end
      K_MAXI: begin s = ($signed(x) > $signed(y)); r = s ? x : y; end
      K_MAXU: begin s = (x > y); r = s ? x : y; end
      K_CSEL: r = s ? x : y;
      K_MUL:  begin t = longint'(x) * longint'(y); r = t[31:0]; end
      K_ABSD: begin t = longint'($signed(x)) - longint'($signed(y));
                    if (t < 0) t = -t; r = t[31:0]; s = (r != 0); end
      default: begin
        case (k)
          K_AND:  r = x & y;
          K_OR:   r = x | y;
          K_XOR:  r = x ^ y;
          K_ANDN: r = x & ~y;
          K_ORN:  r = x | ~y;
          K_NAND: r = ~(x & y);
          K_NOR:  r = ~(x | y);
          K_XNOR: r = ~(x ^ y);
          K_SHL:  r = x << y[4:0];
          K_SHR:  r = x >> y[4:0];
          K_ASR:  r = $signed(x) >>> y[4:0];
          default: r = 0;
        endcase
        s = (r != 0);
      end
    endcase
  endtask

  task automatic check_outputs();
    for (int d = 0; d < 2; d++) begin
      nvec++;
      if (o_v[d] !== e_v || o_ill[d] !== e_ill[d] || o_res[d] !== m_res[d] ||
          o_scc[d] !== m_scc[d] || o_dst[d] !== m_dst[d]) begin
        nbad++;
        $display("FAIL %s map%0d: got v=%b ill=%b res=%h flag=%b dst=%h, expected v=%b ill=%b res=%h flag=%b dst=%h",
                 e_tag, d, o_v[d], o_ill[d], o_res[d], o_scc[d], o_dst[d],
                 e_v, e_ill[d], m_res[d], m_scc[d], m_dst[d]);
      end
    end
  endtask

  // One clock: check the previous expectation, then drive and predict.
  task automatic step(input bit v, input int op0, input int op1, input bit [1:0] fmt,
                      input bit [31:0] x, input bit [31:0] y,
                      input bit we, input bit wv, input string tag);
    int  opc [2];
    bit  s;
    bit [31:0] r;
    bit [6:0]  dd;
    @(negedge clk);
    check_outputs();
    opc[0] = op0; opc[1] = op1;
    seq++;
    dd = 7'(seq);
    in_valid = v; a = x; b = y; fwe = we; fwv = wv;
    e_v = v; e_tag = tag;
    for (int d = 0; d < 2; d++) begin
      int k;
      ins[d] = {fmt, 7'(opc[d]), dd};
      k = (fmt == 2'b10) ? kind_of(opc[d], d) : -1;
      s = m_scc[d];
      e_ill[d] = v && (k < 0);
      if (v && k >= 0) begin
        calc(k, x, y, s, r);
        m_res[d] = r;
        m_dst[d] = dd;
      end
      if (we) s = wv;
      m_scc[d] = s;
    end
  endtask

  task automatic op(input int k, input bit [31:0] x, input bit [31:0] y, input string tag);
    step(1'b1, opc_of(k, 0), opc_of(k, 1), 2'b10, x, y, 1'b0, 1'b0, tag);
  endtask

  task automatic flag(input bit val, input string tag);
    step(1'b0, 0, 0, 2'b10, 32'h0, 32'h0, 1'b1, val, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, 0, 2'b10, 32'h0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nbad++;
      $display("FAIL R2 watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; fwe = 1'b0; fwv = 1'b0;
    ins[0] = '0; ins[1] = '0; a = '0; b = '0;
    e_v = 0; e_tag = "R1";
    for (int d = 0; d < 2; d++) begin
      e_ill[d] = 0; m_scc[d] = 0; m_res[d] = 0; m_dst[d] = 0;
    end
    repeat (3) @(negedge clk);
    check_outputs();               // R1 during reset
    rst_n = 1'b1;
    repeat (5) idle("R1");

    // R3 carry
    op(K_ADDU, 32'hFFFF_FFFF, 32'h1, "R3");
    op(K_ADDC, 32'h5, 32'h6, "R3");
    op(K_ADDU, 32'h1, 32'h2, "R3");
    flag(1'b1, "R13");
    op(K_ADDC, 32'hFFFF_FFFF, 32'h0, "R3");
    op(K_ADDC, 32'h7FFF_FFFF, 32'h8000_0000, "R3");
    // R4 borrow
    op(K_SUBU, 32'h3, 32'h5, "R4");
    op(K_SUBU, 32'h5, 32'h3, "R4");
    flag(1'b1, "R13");
    op(K_SUBB, 32'h5, 32'h5, "R4");
    op(K_SUBB, 32'h7, 32'h2, "R4");
    op(K_SUBB, 32'h0, 32'h0, "R4");
    // R5 signed overflow
    op(K_ADDI, 32'h7FFF_FFFF, 32'h1, "R5");
    op(K_ADDI, 32'hFFFF_FFFF, 32'h1, "R5");
    op(K_ADDI, 32'h8000_0000, 32'h8000_0000, "R5");
    op(K_SUBI, 32'h8000_0000, 32'h1, "R5");
    op(K_SUBI, 32'h5, 32'h7, "R5");
    op(K_SUBI, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5");
    // R6 min / max
    op(K_MINI, 32'hFFFF_FFFF, 32'h1, "R6");
    op(K_MINU, 32'hFFFF_FFFF, 32'h1, "R6");
    op(K_MAXU, 32'h9, 32'h3, "R6");
    op(K_MAXI, 32'h5, 32'h5, "R6");
    op(K_MAXI, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
    op(K_MINU, 32'h4, 32'h4, "R6");
    // R7 select
    flag(1'b1, "R13");
    op(K_CSEL, 32'hAAAA_0001, 32'h5555_0002, "R7");
    op(K_CSEL, 32'hAAAA_0003, 32'h5555_0004, "R7");
    flag(1'b0, "R13");
    op(K_CSEL, 32'hAAAA_0005, 32'h5555_0006, "R7");
    op(K_MAXU, 32'h10, 32'h1, "R6");
    op(K_CSEL, 32'h1111_1111, 32'h2222_2222, "R7");
    // R8 logical
    op(K_AND,  32'hF0F0_F0F0, 32'h0F0F_0F0F, "R8");
    op(K_OR,   32'hF0F0_0000, 32'h0000_0F0F, "R8");
    op(K_XOR,  32'h1234_5678, 32'h1234_5678, "R8");
    op(K_ANDN, 32'hFFFF_0000, 32'h0F0F_0000, "R8");
    op(K_ORN,  32'h0000_0000, 32'hFFFF_FFFF, "R8");
    op(K_NAND, 32'hFFFF_FFFF, 32'h0000_00FF, "R8");
    op(K_NOR,  32'h0000_0000, 32'h0000_0001, "R8");
    op(K_XNOR, 32'hDEAD_BEEF, 32'h2152_4110, "R8");
    op(K_XNOR, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R8");
    // R9 shifts
    op(K_SHL, 32'h1, 32'h21, "R9");
    op(K_SHL, 32'h8000_0000, 32'h1, "R9");
    op(K_SHR, 32'h8000_0000, 32'h1F, "R9");
    op(K_ASR, 32'h8000_0000, 32'h3F, "R9");
    op(K_ASR, 32'h4000_0000, 32'hFFFF_FFE4, "R9");
    // R10 multiply / absolute difference
    flag(1'b1, "R13");
    op(K_MUL, 32'hFFFF_FFFE, 32'h3, "R10");
    op(K_MUL, 32'h0001_0000, 32'h0001_0000, "R10");
    op(K_ABSD, 32'h3, 32'hA, "R10");
    op(K_ABSD, 32'h8000_0000, 32'h1, "R10");
    op(K_ABSD, 32'h5, 32'h5, "R10");
    // R11 opcode 12: illegal in map 0, AND in map 1
    step(1'b1, 12, 12, 2'b10, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 1'b0, "R11");
    step(1'b1, 42, 42, 2'b10, 32'h2, 32'h9, 1'b0, 1'b0, "R11");
    // R12 illegal words
    step(1'b1, 14, 12, 2'b11, 32'h1, 32'h1, 1'b0, 1'b0, "R12");
    step(1'b1, 14, 12, 2'b00, 32'h1, 32'h1, 1'b0, 1'b0, "R12");
    step(1'b1, 11, 11, 2'b10, 32'h1, 32'h2, 1'b0, 1'b0, "R12");
    step(1'b1, 13, 43, 2'b10, 32'h1, 32'h2, 1'b0, 1'b0, "R12");
    step(1'b1, 127, 127, 2'b10, 32'h1, 32'h2, 1'b0, 1'b0, "R12");
    step(1'b1, 15, 13, 2'b10, 32'h3, 32'h3, 1'b0, 1'b0, "R12");
    // R13 priority over an instruction's flag update
    step(1'b1, opc_of(K_ADDU, 0), opc_of(K_ADDU, 1), 2'b10,
         32'hFFFF_FFFF, 32'h2, 1'b1, 1'b0, "R13");
    step(1'b1, opc_of(K_AND, 0), opc_of(K_AND, 1), 2'b10,
         32'h0, 32'h0, 1'b1, 1'b1, "R13");
    idle("R2");
    // R2 random back-to-back mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = int'($urandom_range(K_COUNT - 1, 0));
      if ($urandom_range(7, 0) == 0)
        step(1'b1, int'($urandom_range(127, 0)), int'($urandom_range(127, 0)),
             2'($urandom_range(3, 0)), $urandom, $urandom,
             1'b0, 1'b0, "R2");
      else if ($urandom_range(5, 0) == 0)
        idle("R2");
      else
        op(k, $urandom, ($urandom_range(1, 0) == 1) ? $urandom : 32'($urandom_range(40, 0)), "R2");
    end
    idle("R2");
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule